// File: doc/BRIEF.md
# Slave-Mode Controlled Up/Down Timer

This block is a general-purpose counter whose count source and run control are chosen by a three-bit slave-mode field. The counter can advance on every clock cycle, follow a two-channel quadrature encoder, or step on rising edges of one external trigger chosen from several. In the other trigger-driven modes, a trigger event can restart the count, gate counting, or start the counter. The counter counts between zero and a reload value in either direction. Each time it wraps, it raises a one-cycle update pulse.

Software reaches the block through a small word-wide register port with four locations: control, mode, counter and reload. The reload value can be double-buffered, so that a new period takes effect only at a period boundary. All trigger and encoder pins are asynchronous to the block clock. Each one passes through a two-stage synchroniser before any level or edge is used.

Top module: `slave_timer`

## Requirements
- R1: Register addresses are 0 control, 1 mode, 2 counter and 3 reload. In control, bit 0 is run enable, bit 4 is direction (1 means down) and bit 7 is reload double-buffering. In mode, bits 2:0 are the slave mode and bits 5:4 are the trigger index. After reset, control, mode and counter read 0, reload reads all ones, and the update pulse is low.
- R2: In mode 0 the counter moves by one each clock while run enable is set, in the direction given by the direction bit. With run enable clear, the counter holds its value.
- R3: Counting up, the step from the reload value goes to 0. Counting down, the step from 0 goes to the reload value. On the same cycle that the wrapped value appears, the update output is high for that one cycle.
- R4: With double-buffering off, a reload write takes effect at once. With it on, the written value reads back at once but becomes the wrap limit only at the next update event.
- R5: Trigger and encoder pins are synchronised through two flops. Only the trigger whose index is in mode bits 5:4 affects the counter.
- R6: In mode 4 the counter runs as in mode 0. A rising edge on the selected trigger reloads the start value: 0 when counting up, the reload value when counting down.
- R7: In mode 5 the counter steps only on cycles where the synchronised selected trigger is high. While the trigger is low, the counter holds its value without clearing.
- R8: In mode 6 a rising edge on the selected trigger sets run enable, and the counter value is kept. Counting then proceeds as in mode 0.
- R9: In mode 7, with run enable set, each rising edge of the selected trigger advances the counter by exactly one.
- R10: Modes 1, 2 and 3 count encoder edges with run enable set, and the direction bit is ignored. Mode 1 counts edges on input B, and a step is up when B's new level equals A. Mode 2 counts edges on input A, and a step is up when A's new level differs from B. Mode 3 counts edges on both inputs.
- R11: A write to the counter address sets the count on the next clock edge, and it overrides any count or restart on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | W | Register write data |
| bus_rdata | output | W | Register read data for bus_addr (combinational) |
| trig_in | input | NTRIG | Asynchronous trigger sources |
| enc_a | input | 1 | Quadrature input A |
| enc_b | input | 1 | Quadrature input B |
| upd_evt | output | 1 | Update pulse on counter wrap |

## Verification
The assertions check four things on every cycle:
- the counter value that accompanies each update pulse, for both directions;
- that the count holds in gated mode while the gate is low;
- that the trigger sets run enable in start mode, and that the trigger restart works in reset mode;
- that a reload write takes effect at once when double-buffering is off.

Other behaviours can only be shown by the bench's scenarios:
- the wrap periods, swept across both directions and several reload values;
- the delayed take-over of a buffered reload value;
- the encoder step counts in each of the three encoder modes and in both rotation senses;
- the rejection of unselected triggers.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    SM_INTCLK  = 3'd0,
    SM_QUAD_B  = 3'd1,
    SM_QUAD_A  = 3'd2,
    SM_QUAD_AB = 3'd3,
    SM_RESTART = 3'd4,
    SM_GATE    = 3'd5,
    SM_START   = 3'd6,
    SM_EXTCLK  = 3'd7
  } slave_mode_e;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_MODE   = 2'd1;
  localparam logic [1:0] A_COUNT  = 2'd2;
  localparam logic [1:0] A_RELOAD = 2'd3;

  localparam int B_RUN  = 0;
  localparam int B_DOWN = 4;
  localparam int B_BUF  = 7;
  localparam int B_TSEL = 4;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] tog
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [2:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[1:0], din[i]};
    end
    assign lvl[i]  = pipe_q[1];
    assign rise[i] = pipe_q[1] & ~pipe_q[2];
    assign tog[i]  = pipe_q[1] ^ pipe_q[2];
  end
endmodule

// File: rtl/tmr_quad.sv
module tmr_quad
  import tmr_pkg::*;
(
  input  slave_mode_e mode,
  input  logic        a_lvl,
  input  logic        b_lvl,
  input  logic        a_tog,
  input  logic        b_tog,
  output logic        step,
  output logic        up
);
  always_comb begin
    step = 1'b0;
    up   = 1'b1;
    unique case (mode)
      SM_QUAD_B: begin
        step = b_tog;
        up   = (b_lvl == a_lvl);
      end
      SM_QUAD_A: begin
        step = a_tog;
        up   = (a_lvl != b_lvl);
      end
      SM_QUAD_AB: begin
        step = a_tog | b_tog;
        up   = a_tog ? (a_lvl != b_lvl) : (b_lvl == a_lvl);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         down,
  input  logic         restart,
  input  logic         cnt_wr,
  input  logic         arr_wr,
  input  logic         buffered,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] arr_shadow,
  output logic [W-1:0] arr_act,
  output logic         upd
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_n, shd_n, act_n;
  logic         upd_n;

  always_comb begin
    cnt_n = cnt;
    shd_n = arr_shadow;
    act_n = arr_act;
    upd_n = 1'b0;
    if (arr_wr) begin
      shd_n = wdata;
      if (!buffered) act_n = wdata;
    end
    if (cnt_wr) begin
      cnt_n = wdata;
    end else if (restart) begin
      cnt_n = down ? arr_act : '0;
    end else if (tick) begin
      if (down) begin
        if (cnt == '0) begin
          cnt_n = shd_n;
          act_n = shd_n;
          upd_n = 1'b1;
        end else begin
          cnt_n = cnt - ONE;
        end
      end else begin
        if (cnt == arr_act) begin
          cnt_n = '0;
          act_n = shd_n;
          upd_n = 1'b1;
        end else begin
          cnt_n = cnt + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      arr_shadow <= '1;
      arr_act    <= '1;
      upd        <= 1'b0;
    end else begin
      cnt        <= cnt_n;
      arr_shadow <= shd_n;
      arr_act    <= act_n;
      upd        <= upd_n;
    end
  end
endmodule

// File: rtl/slave_timer.sv
module slave_timer
  import tmr_pkg::*;
#(
  parameter int W     = 16,
  parameter int NTRIG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  input  logic [NTRIG-1:0] trig_in,
  input  logic             enc_a,
  input  logic             enc_b,
  output logic             upd_evt
);
  localparam int TSW  = (NTRIG > 1) ? $clog2(NTRIG) : 1;
  localparam int NSYN = NTRIG + 2;

  logic rs1_q, rs2_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i = rs2_q;

  logic [NSYN-1:0] lvl, rise, tog;
  tmr_sync_edge #(.N(NSYN)) u_sync (
    .clk(clk), .rst_n(rst_i), .din({enc_b, enc_a, trig_in}),
    .lvl(lvl), .rise(rise), .tog(tog)
  );

  logic        en_q, dir_q, buf_q;
  slave_mode_e mode_q;
  logic [TSW-1:0] tsel_q;
  logic        en_n, dir_n, buf_n;
  slave_mode_e mode_n;
  logic [TSW-1:0] tsel_n;

  logic ctrl_wr, mode_wr, cnt_wr, arr_wr;
  assign ctrl_wr = bus_we && (bus_addr == A_CTRL);
  assign mode_wr = bus_we && (bus_addr == A_MODE);
  assign cnt_wr  = bus_we && (bus_addr == A_COUNT);
  assign arr_wr  = bus_we && (bus_addr == A_RELOAD);

  logic gate_lvl, trig_rise;
  assign gate_lvl  = lvl[tsel_q];
  assign trig_rise = rise[tsel_q];

  logic q_step, q_up;
  tmr_quad u_quad (
    .mode(mode_q), .a_lvl(lvl[NTRIG]), .b_lvl(lvl[NTRIG+1]),
    .a_tog(tog[NTRIG]), .b_tog(tog[NTRIG+1]), .step(q_step), .up(q_up)
  );

  always_comb begin
    en_n   = en_q;
    dir_n  = dir_q;
    buf_n  = buf_q;
    mode_n = mode_q;
    tsel_n = tsel_q;
    if (ctrl_wr) begin
      en_n  = bus_wdata[B_RUN];
      dir_n = bus_wdata[B_DOWN];
      buf_n = bus_wdata[B_BUF];
    end
    if (mode_wr) begin
      mode_n = slave_mode_e'(bus_wdata[2:0]);
      tsel_n = bus_wdata[B_TSEL +: TSW];
    end
    if (mode_q == SM_START && trig_rise) en_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
      buf_q  <= 1'b0;
      mode_q <= SM_INTCLK;
      tsel_q <= '0;
    end else begin
      en_q   <= en_n;
      dir_q  <= dir_n;
      buf_q  <= buf_n;
      mode_q <= mode_n;
      tsel_q <= tsel_n;
    end
  end

  logic tick, step_down, restart;
  always_comb begin
    unique case (mode_q)
      SM_QUAD_B, SM_QUAD_A, SM_QUAD_AB: tick = en_q & q_step;
      SM_GATE:                          tick = en_q & gate_lvl;
      SM_EXTCLK:                        tick = en_q & trig_rise;
      default:                          tick = en_q;
    endcase
  end
  assign step_down = (mode_q inside {SM_QUAD_B, SM_QUAD_A, SM_QUAD_AB}) ? ~q_up : dir_q;
  assign restart   = (mode_q == SM_RESTART) && trig_rise;

  logic [W-1:0] cnt, arr_shadow, arr_act;
  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_i), .tick(tick), .down(step_down),
    .restart(restart), .cnt_wr(cnt_wr), .arr_wr(arr_wr),
    .buffered(buf_q), .wdata(bus_wdata), .cnt(cnt),
    .arr_shadow(arr_shadow), .arr_act(arr_act), .upd(upd_evt)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_RUN]  = en_q;
        bus_rdata[B_DOWN] = dir_q;
        bus_rdata[B_BUF]  = buf_q;
      end
      A_MODE: begin
        bus_rdata[2:0]          = mode_q;
        bus_rdata[B_TSEL +: TSW] = tsel_q;
      end
      A_COUNT:  bus_rdata = cnt;
      default:  bus_rdata = arr_shadow;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input slave_mode_e  mode,
  input logic         trig_rise,
  input logic         gate_lvl,
  input logic         cnt_wr,
  input logic         ctrl_wr,
  input logic         arr_wr,
  input logic         buffered,
  input logic         dir,
  input logic         en,
  input logic         step_down,
  input logic [W-1:0] wdata,
  input logic [W-1:0] cnt,
  input logic [W-1:0] arr_act,
  input logic         upd
);
  assert_wrap_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !$past(step_down)) |-> (cnt == '0));

  assert_wrap_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && $past(step_down)) |-> (cnt == arr_act));

  assert_direct_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr && !buffered) |=> (arr_act == $past(wdata)));

  assert_restart_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SM_RESTART && trig_rise && !cnt_wr && !dir) |=> (cnt == '0));

  assert_gate_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SM_GATE && !gate_lvl && !cnt_wr) |=> (cnt == $past(cnt)));

  assert_start_sets_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SM_START && trig_rise && !ctrl_wr) |=> en);
endmodule

bind slave_timer tmr_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_i), .mode(mode_q), .trig_rise(trig_rise),
  .gate_lvl(gate_lvl), .cnt_wr(cnt_wr), .ctrl_wr(ctrl_wr), .arr_wr(arr_wr),
  .buffered(buf_q), .dir(dir_q), .en(en_q), .step_down(step_down),
  .wdata(bus_wdata), .cnt(cnt), .arr_act(arr_act), .upd(upd_evt)
);

// File: tb/tb_slave_timer.sv
module tb_slave_timer;
  localparam int W = 16;
  localparam int NTRIG = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             bus_we;
  logic [1:0]       bus_addr;
  logic [W-1:0]     bus_wdata;
  logic [W-1:0]     bus_rdata;
  logic [NTRIG-1:0] trig_in;
  logic             enc_a, enc_b;
  logic             upd_evt;

  int total = 0;
  int bad = 0;
  int phase = 0;

  always #2 clk = ~clk;

  slave_timer #(.W(W), .NTRIG(NTRIG)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
    .enc_a(enc_a), .enc_b(enc_b), .upd_evt(upd_evt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = W'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic qstep(input bit fwd);
    phase = fwd ? (phase + 1) % 4 : (phase + 3) % 4;
    enc_a = (phase == 1) || (phase == 2);
    enc_b = (phase == 2) || (phase == 3);
    cyc(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, ev, n, k;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    trig_in = '0; enc_a = 1'b0; enc_b = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1 reset state
    rd(2'd0, v); chk(v == 0, "R1 ctrl reset", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 mode reset", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 count reset", v, 0);
    rd(2'd3, v); chk(v == 65535, "R1 reload reset", v, 65535);
    chk(upd_evt == 1'b0, "R1 update low", int'(upd_evt), 0);

    // R2 R3 sweep: both directions, several periods
    for (int dn = 0; dn < 2; dn++) begin
      for (int arr = 1; arr <= 6; arr++) begin
        wr(2'd0, 0);
        wr(2'd3, arr);
        wr(2'd2, dn ? arr : 0);
        wr(2'd0, 1 | (dn << 4));
        bus_addr = 2'd2;
        n = 17; ev = 0;
        repeat (n) begin
          @(negedge clk);
          ev += int'(upd_evt);
        end
        k = n % (arr + 1);
        rd(2'd2, v);
        chk(v == (dn ? arr - k : k), "R2 count after run", v, dn ? arr - k : k);
        chk(ev == n / (arr + 1), "R3 update count", ev, n / (arr + 1));
      end
    end

    // R2 hold when disabled
    wr(2'd0, 0);
    rd(2'd2, k);
    cyc(5);
    rd(2'd2, v); chk(v == k, "R2 hold with run clear", v, k);

    // R11 counter write overrides counting
    wr(2'd3, 1000);
    wr(2'd2, 0);
    wr(2'd0, 1);
    cyc(3);
    wr(2'd2, 40);
    rd(2'd2, v); chk(v == 40, "R11 write wins", v, 40);
    cyc(1);
    rd(2'd2, v); chk(v == 41, "R11 count resumes", v, 41);

    // R4 buffered reload
    wr(2'd0, 0);
    wr(2'd3, 3);
    wr(2'd0, 8'h80);
    wr(2'd3, 9);
    rd(2'd3, v); chk(v == 9, "R4 readback shadow", v, 9);
    wr(2'd2, 0);
    wr(2'd0, 8'h81);
    bus_addr = 2'd2;
    ev = 0;
    repeat (4) begin @(negedge clk); ev += int'(upd_evt); end
    rd(2'd2, v);
    chk(ev == 1 && upd_evt && v == 0, "R4 old limit used first", v, 0);
    ev = 0;
    repeat (9) begin @(negedge clk); ev += int'(upd_evt); end
    rd(2'd2, v); chk(ev == 0 && v == 9, "R4 new limit after update", v, 9);
    @(negedge clk);
    rd(2'd2, v); chk(upd_evt && v == 0, "R4 wrap at new limit", v, 0);

    // R10 encoder modes, direction bit set but ignored
    wr(2'd0, 0);
    wr(2'd3, 1000);
    for (int m = 1; m <= 3; m++) begin
      wr(2'd1, m);
      wr(2'd2, 100);
      wr(2'd0, 1 | (1 << 4));
      for (int s = 0; s < 8; s++) qstep(1'b1);
      cyc(4);
      rd(2'd2, v);
      chk(v == 100 + ((m == 3) ? 8 : 4), "R10 forward steps", v, 100 + ((m == 3) ? 8 : 4));
      for (int s = 0; s < 8; s++) qstep(1'b0);
      cyc(4);
      rd(2'd2, v); chk(v == 100, "R10 reverse steps", v, 100);
      wr(2'd0, 0);
    end

    // R7 R5 gated on trigger 2, noise on trigger 0
    wr(2'd2, 50);
    wr(2'd1, 5 | (2 << 4));
    wr(2'd0, 1);
    cyc(5);
    rd(2'd2, v); chk(v == 50, "R7 gate low holds", v, 50);
    trig_in[0] = 1'b1;
    cyc(4);
    rd(2'd2, v); chk(v == 50, "R5 unselected trigger ignored", v, 50);
    trig_in[2] = 1'b1;
    cyc(6);
    trig_in[2] = 1'b0;
    cyc(8);
    rd(2'd2, v); chk(v == 56, "R7 gated count", v, 56);
    cyc(5);
    rd(2'd2, v); chk(v == 56, "R7 frozen not cleared", v, 56);
    trig_in[0] = 1'b0;

    // R9 R5 external edge clock on trigger 1
    wr(2'd0, 0);
    wr(2'd2, 0);
    wr(2'd1, 7 | (1 << 4));
    wr(2'd0, 1);
    for (int i = 0; i < 5; i++) begin
      trig_in[1] = 1'b1; trig_in[0] = 1'b1; trig_in[3] = 1'b0;
      cyc(3);
      trig_in[1] = 1'b0; trig_in[0] = 1'b0; trig_in[3] = 1'b1;
      cyc(3);
    end
    trig_in[3] = 1'b0;
    cyc(5);
    rd(2'd2, v); chk(v == 5, "R9 edge count", v, 5);

    // R6 restart on trigger 3
    wr(2'd0, 0);
    wr(2'd3, 1000);
    wr(2'd2, 0);
    wr(2'd1, 4 | (3 << 4));
    wr(2'd0, 1);
    bus_addr = 2'd2;
    cyc(20);
    rd(2'd2, v); chk(v == 20, "R6 runs freely", v, 20);
    trig_in[3] = 1'b1;
    cyc(3);
    rd(2'd2, v); chk(v == 0, "R6 restart up", v, 0);
    cyc(4);
    rd(2'd2, v); chk(v == 4, "R6 keeps counting", v, 4);
    trig_in[3] = 1'b0;
    wr(2'd0, 1 | (1 << 4));
    cyc(5);
    trig_in[3] = 1'b1;
    cyc(3);
    rd(2'd2, v); chk(v == 1000, "R6 restart down", v, 1000);
    trig_in[3] = 1'b0;

    // R8 triggered start on trigger 0
    wr(2'd0, 0);
    wr(2'd2, 7);
    wr(2'd1, 6);
    cyc(4);
    rd(2'd0, v); chk((v & 1) == 0, "R8 idle before trigger", v, 0);
    trig_in[0] = 1'b1;
    cyc(3);
    rd(2'd0, v); chk((v & 1) == 1, "R8 run set by trigger", v & 1, 1);
    rd(2'd2, v); chk(v == 7, "R8 count kept", v, 7);
    cyc(4);
    rd(2'd2, v); chk(v == 11, "R8 counting after start", v, 11);
    trig_in[0] = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule